// File: doc/BRIEF.md
# Serpent Bitslice Encryption Round Engine

This block encrypts one 128-bit block with the Serpent cipher, one round per clock cycle. The state is kept as four 32-bit words. In each substitution round the engine XORs the current round key into the state, passes every bit position through a 4-bit S-box, and then mixes the words with a fixed linear transform. A round counter picks which of the eight S-box types is used. The S-box of a lane takes its four input bits from the same bit position in the four words.

The key schedule sits outside the block. The engine puts the index of the round key it needs on `key_addr` and expects that key on `key_in` in the same cycle, so a plain combinational key store can sit behind it. The last substitution round skips the linear transform. One further cycle then XORs the 33rd key into the state. After that cycle the engine raises `done` for one cycle and holds the ciphertext on `block_out` until the next block is started.

Top module: `serpent_round_core`

## Requirements
- R1: While `rst_n` is low, and as soon as it falls (asynchronously), `busy` and `done` are 0 and `key_addr` is 0.
- R2: A `start` seen at a rising edge while idle loads `block_in` and raises `busy` on that edge. A `start` seen while `busy` is high is ignored and leaves the result unchanged.
- R3: While `busy` is high, `key_addr` steps through 0, 1, …, 32, moving up by one each cycle, and `key_in` is used in the cycle its index is presented.
- R4: Word k of the state is bits [32k+31:32k] of the block. For rounds i = 0…30 the engine computes S_(i mod 8)(state XOR K_i). The lane at bit p forms its nibble as {w3[p], w2[p], w1[p], w0[p]} and writes output bit k back to w_k[p]. The tables are S0={3,8,15,1,10,6,5,11,14,13,4,2,7,0,9,12}, S1={15,12,2,7,9,0,5,10,1,11,14,8,6,13,3,4}, S2={8,6,7,9,3,12,10,15,13,1,14,4,0,11,5,2}, S3={0,15,11,8,12,9,6,3,13,1,2,4,10,7,5,14}, S4={1,15,8,3,12,0,11,6,2,5,4,10,9,14,7,13}, S5={15,5,2,11,4,10,9,12,0,3,14,8,13,6,7,1}, S6={7,2,12,5,8,4,6,11,14,9,1,15,13,3,10,0} and S7={1,13,15,0,14,8,2,11,7,4,12,10,9,3,5,6}.
- R5: After each of rounds 0…30 the words are mixed in this order: w0<<<=13, w2<<<=3, w1^=w0^w2, w3^=w2^(w0<<3), w1<<<=1, w3<<<=7, w0^=w1^w3, w2^=w3^(w1<<7), w0<<<=5, w2<<<=22.
- R6: Round 31 applies S7 to (state XOR K31) with no linear transform. The following cycle XORs in K32.
- R7: `done` is a one-cycle pulse that rises exactly 33 rising edges after the loading edge. `busy` falls on the same edge.
- R8: While idle, `block_out` holds the last result until a new block is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin encrypting `block_in` (honoured only when idle) |
| block_in | input | 128 | Plaintext block, word k in bits [32k+31:32k] |
| key_in | input | 128 | Round key selected by `key_addr`, valid in the same cycle |
| key_addr | output | 6 | Index of the round key needed this cycle |
| busy | output | 1 | High while rounds are running |
| done | output | 1 | One-cycle pulse when `block_out` holds the ciphertext |
| block_out | output | 128 | Ciphertext, held until the next start |

## Verification
The state is never visible until the very end, so an error in any lane, S-box entry, rotation amount or key index shows up only in the ciphertext. It appears there 33 cycles after loading, and the avalanche of the rounds spreads it across the whole word. The round-by-round key addresses are compared cycle by cycle, so an early or late counter is caught in the cycle it occurs. The seeds and blocks cover all-zero, all-one and mixed patterns. A wrong S-box type, a wrong bit order or a missing final key therefore changes the comparison for every vector. The latency and the shape of the pulse are checked at the edge where `done` should rise and at the edge after it.

// File: rtl/serpent_pkg.sv
package serpent_pkg;

  localparam int WORD_W  = 32;
  localparam int N_WORDS = 4;
  localparam int BLOCK_W = WORD_W * N_WORDS;
  localparam int ROUNDS  = 32;
  localparam int N_KEYS  = ROUNDS + 1;
  localparam int KA_W    = $clog2(N_KEYS);
  localparam int N_TYPES = 8;
  localparam int TYPE_W  = $clog2(N_TYPES);

  typedef logic [N_WORDS-1:0][WORD_W-1:0] words_t;

  typedef enum logic {PH_IDLE = 1'b0, PH_RUN = 1'b1} phase_e;

  // Packed table rows: entry n sits in bits [4n+3:4n].
  function automatic logic [63:0] sbox_row(input logic [TYPE_W-1:0] t);
    logic [63:0] r;
    case (t)
      3'd0:    r = 64'hC907_24DE_B56A_1F83;
      3'd1:    r = 64'h43D6_8EB1_A509_72CF;
      3'd2:    r = 64'h25B0_4E1D_FAC3_9768;
      3'd3:    r = 64'hE57A_421D_369C_8BF0;
      3'd4:    r = 64'hD7E9_A452_6B0C_38F1;
      3'd5:    r = 64'h176D_8E30_C9A4_B25F;
      3'd6:    r = 64'h0A3D_F19E_B648_5C27;
      default: r = 64'h6539_AC47_B28E_0FD1;
    endcase
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] v, input int n);
    return (v << n) | (v >> (WORD_W - n));
  endfunction

endpackage

// File: rtl/serpent_sbox_lane.sv
module serpent_sbox_lane
  import serpent_pkg::*;
(
  input  logic [TYPE_W-1:0] sel,
  input  logic [3:0]        nib_i,
  output logic [3:0]        nib_o
);

  logic [63:0] row;

  always_comb begin
    row   = sbox_row(sel);
    nib_o = row[{nib_i, 2'b00} +: 4];
  end

endmodule

// File: rtl/serpent_sub_layer.sv
module serpent_sub_layer
  import serpent_pkg::*;
(
  input  logic [TYPE_W-1:0] sel,
  input  words_t            din,
  output words_t            dout
);

  for (genvar p = 0; p < WORD_W; p++) begin : g_lane
    logic [3:0] nib_in;
    logic [3:0] nib_out;

    assign nib_in = {din[3][p], din[2][p], din[1][p], din[0][p]};

    serpent_sbox_lane u_lane (
      .sel   (sel),
      .nib_i (nib_in),
      .nib_o (nib_out)
    );

    assign dout[0][p] = nib_out[0];
    assign dout[1][p] = nib_out[1];
    assign dout[2][p] = nib_out[2];
    assign dout[3][p] = nib_out[3];
  end

endmodule

// File: rtl/serpent_mix.sv
module serpent_mix
  import serpent_pkg::*;
(
  input  words_t din,
  output words_t dout
);

  localparam int ROT_A0 = 13;
  localparam int ROT_A2 = 3;
  localparam int SHL_A  = 3;
  localparam int ROT_B1 = 1;
  localparam int ROT_B3 = 7;
  localparam int SHL_B  = 7;
  localparam int ROT_C0 = 5;
  localparam int ROT_C2 = 22;

  logic [WORD_W-1:0] a0, a2, a1, a3;
  logic [WORD_W-1:0] b1, b3, b0, b2;

  always_comb begin
    a0 = rotl(din[0], ROT_A0);
    a2 = rotl(din[2], ROT_A2);
    a1 = din[1] ^ a0 ^ a2;
    a3 = din[3] ^ a2 ^ (a0 << SHL_A);
    b1 = rotl(a1, ROT_B1);
    b3 = rotl(a3, ROT_B3);
    b0 = a0 ^ b1 ^ b3;
    b2 = a2 ^ b3 ^ (b1 << SHL_B);
    dout[0] = rotl(b0, ROT_C0);
    dout[1] = b1;
    dout[2] = rotl(b2, ROT_C2);
    dout[3] = b3;
  end

endmodule

// File: rtl/serpent_seq.sv
module serpent_seq
  import serpent_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic [KA_W-1:0] cnt,
  output logic            load,
  output logic            step,
  output logic            busy,
  output logic            done
);

  localparam logic [KA_W-1:0] LAST = KA_W'(N_KEYS - 1);

  phase_e          ph_q, ph_d;
  logic [KA_W-1:0] cnt_q, cnt_d;
  logic            done_q, done_d;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d  = PH_RUN;
          cnt_d = '0;
        end
      end
      default: begin
        if (cnt_q == LAST) begin
          ph_d   = PH_IDLE;
          cnt_d  = '0;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign cnt  = cnt_q;
  assign load = (ph_q == PH_IDLE) && start;
  assign step = (ph_q == PH_RUN);
  assign busy = (ph_q == PH_RUN);
  assign done = done_q;

endmodule

// File: rtl/serpent_round_core.sv
module serpent_round_core
  import serpent_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [BLOCK_W-1:0] block_in,
  input  logic [BLOCK_W-1:0] key_in,
  output logic [KA_W-1:0]    key_addr,
  output logic               busy,
  output logic               done,
  output logic [BLOCK_W-1:0] block_out
);

  localparam logic [KA_W-1:0] LAST_SUB = KA_W'(ROUNDS - 1);
  localparam logic [KA_W-1:0] WHITEN   = KA_W'(ROUNDS);

  // Reset: asserted at once, released after two clock edges.
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic [KA_W-1:0] cnt;
  logic            load, step;

  serpent_seq u_seq (
    .clk   (clk),
    .rst_n (rst_core_n),
    .start (start),
    .cnt   (cnt),
    .load  (load),
    .step  (step),
    .busy  (busy),
    .done  (done)
  );

  words_t state_q, state_d;
  words_t keyed, subbed, mixed;
  logic   state_en;
  logic   is_last_sub, is_whiten;

  assign keyed = state_q ^ key_in;

  serpent_sub_layer u_sub (
    .sel  (cnt[TYPE_W-1:0]),
    .din  (keyed),
    .dout (subbed)
  );

  serpent_mix u_mix (
    .din  (subbed),
    .dout (mixed)
  );

  always_comb begin
    is_last_sub = step && (cnt == LAST_SUB);
    is_whiten   = step && (cnt == WHITEN);
    state_en    = load || step;
    if (load)             state_d = block_in;
    else if (is_whiten)   state_d = keyed;
    else if (is_last_sub) state_d = subbed;
    else                  state_d = mixed;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)   state_q <= '0;
    else if (state_en) state_q <= state_d;
  end

  assign key_addr  = cnt;
  assign block_out = state_q;

endmodule

// File: rtl/serpent_round_core_chk.sv
module serpent_round_core_chk #(
  parameter int AW   = 6,
  parameter int LAST = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [AW-1:0]  key_addr,
  input logic [127:0]   block_out
);

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && key_addr == '0));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (key_addr == AW'($past(key_addr) + 1'b1)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && key_addr == AW'(LAST)) |=> (done && !busy));

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(block_out));

  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_idle_chk: assert (!busy && !done && key_addr == '0);
    end
  end

endmodule

bind serpent_round_core serpent_round_core_chk u_chk (.*);

// File: tb/tb_serpent_round_core.sv
module tb_serpent_round_core;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [127:0] block_in;
  logic [127:0] key_in;
  logic [5:0]   key_addr;
  logic         busy;
  logic         done;
  logic [127:0] block_out;

  int n_checks = 0;
  int n_fails  = 0;
  logic [31:0] cur_seed = 32'h0;

  always #4 clk = ~clk;

  serpent_round_core dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .block_in  (block_in),
    .key_in    (key_in),
    .key_addr  (key_addr),
    .busy      (busy),
    .done      (done),
    .block_out (block_out)
  );

  localparam int SB0 [16] = '{3,8,15,1,10,6,5,11,14,13,4,2,7,0,9,12};
  localparam int SB1 [16] = '{15,12,2,7,9,0,5,10,1,11,14,8,6,13,3,4};
  localparam int SB2 [16] = '{8,6,7,9,3,12,10,15,13,1,14,4,0,11,5,2};
  localparam int SB3 [16] = '{0,15,11,8,12,9,6,3,13,1,2,4,10,7,5,14};
  localparam int SB4 [16] = '{1,15,8,3,12,0,11,6,2,5,4,10,9,14,7,13};
  localparam int SB5 [16] = '{15,5,2,11,4,10,9,12,0,3,14,8,13,6,7,1};
  localparam int SB6 [16] = '{7,2,12,5,8,4,6,11,14,9,1,15,13,3,10,0};
  localparam int SB7 [16] = '{1,13,15,0,14,8,2,11,7,4,12,10,9,3,5,6};

  localparam int NV = 6;
  localparam logic [127:0] VEC_BLK [NV] = '{
    128'h0,
    {4{32'hFFFF_FFFF}},
    128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF,
    128'h8000_0000_0000_0000_0000_0000_0000_0001,
    128'hDEAD_BEEF_0123_4567_89AB_CDEF_F00D_CAFE,
    128'h5A5A_A5A5_3C3C_C3C3_0F0F_F0F0_6996_9669
  };
  localparam logic [31:0] VEC_SEED [NV] = '{
    32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678,
    32'h0000_0001, 32'hCAFE_F00D, 32'h7777_1111
  };
  localparam int VEC_POKE [NV] = '{-1, -1, 5, -1, 31, 17};

  function automatic logic [127:0] keygen(input logic [31:0] s, input int a);
    logic [127:0] k;
    for (int w = 0; w < 4; w++)
      k[32*w +: 32] = ((s ^ (32'(a) << 8)) * 32'h0100_0193) + 32'(w) * 32'h3C6E_F372 + 32'(a);
    return k;
  endfunction

  always_comb key_in = keygen(cur_seed, int'(key_addr));

  function automatic logic [3:0] ref_sb(input int t, input logic [3:0] v);
    int r;
    case (t)
      0: r = SB0[v];
      1: r = SB1[v];
      2: r = SB2[v];
      3: r = SB3[v];
      4: r = SB4[v];
      5: r = SB5[v];
      6: r = SB6[v];
      default: r = SB7[v];
    endcase
    return 4'(r);
  endfunction

  function automatic logic [31:0] brot(input logic [31:0] v, input int n);
    logic [63:0] t;
    t = {v, v} << n;
    return t[63:32];
  endfunction

  function automatic logic [127:0] ref_encrypt(input logic [127:0] blk, input logic [31:0] s);
    logic [31:0] w [4];
    logic [31:0] n [4];
    logic [127:0] k;
    logic [3:0] v, o;
    for (int j = 0; j < 4; j++) w[j] = blk[32*j +: 32];
    for (int r = 0; r < 32; r++) begin
      k = keygen(s, r);
      for (int j = 0; j < 4; j++) w[j] = w[j] ^ k[32*j +: 32];
      for (int p = 0; p < 32; p++) begin
        v = {w[3][p], w[2][p], w[1][p], w[0][p]};
        o = ref_sb(r % 8, v);
        for (int j = 0; j < 4; j++) n[j][p] = o[j];
      end
      for (int j = 0; j < 4; j++) w[j] = n[j];
      if (r < 31) begin
        w[0] = brot(w[0], 13);
        w[2] = brot(w[2], 3);
        w[1] = w[1] ^ w[0] ^ w[2];
        w[3] = w[3] ^ w[2] ^ (w[0] << 3);
        w[1] = brot(w[1], 1);
        w[3] = brot(w[3], 7);
        w[0] = w[0] ^ w[1] ^ w[3];
        w[2] = w[2] ^ w[3] ^ (w[1] << 7);
        w[0] = brot(w[0], 5);
        w[2] = brot(w[2], 22);
      end
    end
    k = keygen(s, 32);
    return {w[3], w[2], w[1], w[0]} ^ k;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [127:0] blk, input logic [31:0] s, input int poke);
    logic [127:0] exp;
    int lat;
    int idx;
    bit addr_ok;
    logic [5:0] bad_addr;
    exp      = ref_encrypt(blk, s);
    cur_seed = s;
    addr_ok  = 1'b1;
    bad_addr = '0;
    idx      = 0;
    lat      = 0;
    @(negedge clk);
    block_in = blk;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R2 busy after load", 128'(busy), 128'd1);
    while (!done && lat < 100) begin
      if (busy) begin
        if (key_addr !== 6'(idx) && addr_ok) begin
          addr_ok  = 1'b0;
          bad_addr = key_addr;
        end
        idx++;
      end
      if (lat == poke) begin
        start    = 1'b1;
        block_in = ~blk;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check(addr_ok && idx == 33, "R3 key address sequence", 128'(bad_addr), 128'(idx));
    check(lat == 33, "R7 latency to done", 128'(lat), 128'd33);
    check(block_out === exp, (poke >= 0) ? "R2 R4 R5 R6 result with ignored start"
                                         : "R4 R5 R6 ciphertext", block_out, exp);
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R7 done single pulse", 128'({busy, done}), 128'd0);
    repeat (3) @(negedge clk);
    check(block_out === exp, "R8 output held while idle", block_out, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    start    = 1'b0;
    block_in = '0;
    repeat (3) @(negedge clk);
    // R1: idle state while in reset
    check(busy === 1'b0 && done === 1'b0 && key_addr === 6'd0, "R1 reset state",
          128'({busy, done, key_addr}), 128'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < NV; v++) run_vec(VEC_BLK[v], VEC_SEED[v], VEC_POKE[v]);

    // R1: asynchronous reset in the middle of a run
    cur_seed = 32'hABCD_0001;
    @(negedge clk);
    block_in = 128'h1;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (9) @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    check(busy === 1'b0 && done === 1'b0 && key_addr === 6'd0, "R1 async reset mid-run",
          128'({busy, done, key_addr}), 128'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1 idle after reset release",
          128'({busy, done}), 128'd0);

    // recovery after reset: back-to-back blocks
    run_vec(128'hFEDC_BA98_7654_3210_0123_4567_89AB_CDEF, 32'h0BAD_CAFE, -1);
    run_vec(128'h0000_0001_0000_0000_0000_0000_0000_0000, 32'h0BAD_CAFE, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule